// File: doc/BRIEF.md
# Video Scanline Timing and Interrupts

This block keeps the vertical position of a video raster. A free-running time base, qualified by a tick enable, is divided into scanlines. The division ratio and the lines per frame belong to either the 525-line (NTSC) or the 625-line (PAL) standard. The block reports the current line number. At the end of every frame it emits a one-cycle retrace pulse. It also raises two independent scanline-compare pulses at programmed lines.

Retrace does not hand the finished frame to the display at once. It arms a pending flag instead. The frame is presented by a one-cycle strobe when the raster reaches a fixed line after the wrap, or earlier if software writes a new frame base address while the flag is armed. Each present strobe advances a frame counter. The standard select input is sampled only at frame boundaries, so a change never cuts a frame short.

Top module: `vline_timing`

## Requirements
- R1: The line number advances by one after every P ticked clock edges, where P is NTSC_CYC in NTSC mode and PAL_CYC in PAL mode. Edges with `tick_i` low leave both the line number and the position within the line unchanged.
- R2: When the line number would reach the frame's total (525 for NTSC, 625 for PAL), it returns to 0. `retrace_o` is high for exactly the one cycle in which `line_o` first shows 0, and the pending-present flag is set.
- R3: `pal_sel_i` (1 = PAL, 0 = NTSC) is sampled only on the clock edge of a frame wrap and governs the whole following frame, both its total line count and its line period.
- R4: A write (`cmp_wr_i` high) loads compare A from `cmp_wdata_i[25:16]` and compare B from `cmp_wdata_i[9:0]`. All other bits of the word are ignored.
- R5: `line_hit_o[0]` (compare A) and `line_hit_o[1]` (compare B) each pulse for one cycle, in the cycle in which `line_o` first shows a value equal to that compare. Both may pulse on the same line.
- R6: When the line number becomes 65 while the pending flag is set, `present_o` pulses in that same cycle and the flag is cleared.
- R7: A `base_wr_i` pulse sampled while the flag is set makes `present_o` high in the following cycle and clears the flag. A `base_wr_i` pulse sampled while the flag is clear has no effect.
- R8: Only one present strobe is produced per armed flag. A base write sampled on the same edge as the advance to line 65 gives a single one-cycle strobe and a single count.
- R9: `frame_cnt_o` increases by exactly one in the cycle of each `present_o` pulse and at no other time.
- R10: Reset sets the line number, sub-line position, both compares, the pending flag and the frame counter to 0, drives all pulse outputs low, and selects NTSC for the first frame whatever `pal_sel_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable; one tick is one unit of line period |
| pal_sel_i | input | 1 | Standard request, 1 = PAL, 0 = NTSC, taken at frame wrap |
| cmp_wr_i | input | 1 | Write strobe for the packed compare word |
| cmp_wdata_i | input | 32 | Packed compare word (A in 25:16, B in 9:0) |
| base_wr_i | input | 1 | Frame base address write strobe |
| retrace_o | output | 1 | Frame wrap pulse |
| line_hit_o | output | 2 | Scanline-compare pulses, bit 0 = A, bit 1 = B |
| present_o | output | 1 | Present-frame strobe |
| line_o | output | LINE_W | Current line number |
| frame_cnt_o | output | FRAME_CNT_W | Count of presented frames |

## Verification
The hardest case to reach is R8, where a base-address write lands on exactly the clock edge that moves the raster onto line 65. The write must be aligned to the sub-line phase, not just to the line. The bench shortens the line period to two clock cycles. It waits for the negative edge right after the line changes to 64, lets one more edge pass, and then raises the write for a single cycle. That edge is the one that advances the line. A second delicate case is the standard change: the bench requests PAL in mid-frame and first confirms that the current frame still wraps at 525 lines, and only then looks for the 625-line frame with its longer period.

// File: rtl/vline_pkg.sv
package vline_pkg;

   typedef enum logic {
      STD_NTSC = 1'b0,
      STD_PAL  = 1'b1
   } vstd_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vline_tick_div.sv
module vline_tick_div #(
   parameter int MAX_CYC = 864,
   localparam int CYC_W  = $clog2(MAX_CYC + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CYC_W-1:0] period_i,
   output logic             adv_o
);

   logic [CYC_W-1:0] cnt_q;
   logic             last_w;

   assign last_w = (cnt_q >= period_i - 1'b1);
   assign adv_o  = tick_i && last_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= last_w ? '0 : cnt_q + 1'b1;
   end

   // sub-line position never reaches the period of the active standard
   assert_cnt_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < period_i);

   // an idle time base freezes the sub-line position
   assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/vline_counter.sv
module vline_counter
   import vline_pkg::*;
#(
   parameter int LINE_W     = 10,
   parameter int NTSC_LINES = 525,
   parameter int PAL_LINES  = 625,
   localparam int TW        = LINE_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  logic              pal_sel_i,
   output logic [LINE_W-1:0] line_o,
   output logic [LINE_W-1:0] nxt_line_o,
   output logic              wrap_o,
   output vstd_e             std_o,
   output logic              retrace_o
);

   logic [LINE_W-1:0] line_q;
   vstd_e             std_q;
   logic              retrace_q;
   logic [TW-1:0]     total_w;
   logic [TW-1:0]     inc_w;

   assign total_w    = (std_q == STD_PAL) ? TW'(PAL_LINES) : TW'(NTSC_LINES);
   assign inc_w      = {1'b0, line_q} + 1'b1;
   assign wrap_o     = adv_i && (inc_w == total_w);
   assign nxt_line_o = (inc_w == total_w) ? '0 : inc_w[LINE_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q    <= '0;
         std_q     <= STD_NTSC;
         retrace_q <= 1'b0;
      end else begin
         if (adv_i)
            line_q <= nxt_line_o;
         if (wrap_o)
            std_q <= pal_sel_i ? STD_PAL : STD_NTSC;
         retrace_q <= wrap_o;
      end
   end

   assign line_o    = line_q;
   assign std_o     = std_q;
   assign retrace_o = retrace_q;

   assert_line_below_total_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {1'b0, line_q} < total_w);

   assert_retrace_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retrace_q |-> (line_q == '0));

   assert_line_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(line_q));

   assert_std_frame_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap_o |=> $stable(std_q));

endmodule

// File: rtl/vline_present.sv
module vline_present #(
   parameter int LINE_W       = 10,
   parameter int FRAME_CNT_W  = 16,
   parameter int PRESENT_LINE = 65
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   adv_i,
   input  logic [LINE_W-1:0]      nxt_line_i,
   input  logic                   wrap_i,
   input  logic                   base_wr_i,
   output logic                   present_o,
   output logic [FRAME_CNT_W-1:0] frame_cnt_o
);

   logic                   pend_q;
   logic                   present_q;
   logic [FRAME_CNT_W-1:0] frame_q;
   logic                   hit_line_w;
   logic                   fire_w;

   assign hit_line_w = adv_i && (nxt_line_i == LINE_W'(PRESENT_LINE));
   assign fire_w     = pend_q && (hit_line_w || base_wr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= 1'b0;
         present_q <= 1'b0;
         frame_q   <= '0;
      end else begin
         if (wrap_i)
            pend_q <= 1'b1;
         else if (fire_w)
            pend_q <= 1'b0;
         present_q <= fire_w;
         frame_q   <= frame_q + FRAME_CNT_W'(fire_w);
      end
   end

   assign present_o   = present_q;
   assign frame_cnt_o = frame_q;

   assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      present_q |=> !present_q);

   assert_frame_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      present_q |-> (frame_q == $past(frame_q) + 1'b1));

   assert_frame_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !present_q |-> $stable(frame_q));

   assert_no_strobe_unarmed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q |=> !present_q);

endmodule

// File: rtl/vline_timing.sv
module vline_timing
   import vline_pkg::*;
#(
   parameter int LINE_W       = 10,
   parameter int NTSC_LINES   = 525,
   parameter int PAL_LINES    = 625,
   parameter int NTSC_CYC     = 858,
   parameter int PAL_CYC      = 864,
   parameter int PRESENT_LINE = 65,
   parameter int FRAME_CNT_W  = 16,
   localparam int NUM_CMP     = 2,
   localparam int MAX_CYC     = max2(NTSC_CYC, PAL_CYC),
   localparam int CYC_W       = $clog2(MAX_CYC + 1)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   tick_i,
   input  logic                   pal_sel_i,
   input  logic                   cmp_wr_i,
   input  logic [31:0]            cmp_wdata_i,
   input  logic                   base_wr_i,
   output logic                   retrace_o,
   output logic [NUM_CMP-1:0]     line_hit_o,
   output logic                   present_o,
   output logic [LINE_W-1:0]      line_o,
   output logic [FRAME_CNT_W-1:0] frame_cnt_o
);

   // field positions of the packed compare word: A above, B below
   localparam int CMP_LSB [NUM_CMP] = '{16, 0};

   if (LINE_W > 16 || LINE_W < 1) begin : g_bad_width
      $error("LINE_W must lie in 1..16 to fit the packed compare word");
   end
   if ((2 ** LINE_W) < PAL_LINES || (2 ** LINE_W) < NTSC_LINES) begin : g_bad_lines
      $error("line totals do not fit in LINE_W bits");
   end
   if (PRESENT_LINE < 1 || PRESENT_LINE >= NTSC_LINES || PRESENT_LINE >= PAL_LINES) begin : g_bad_present
      $error("PRESENT_LINE must fall strictly inside both frames");
   end
   if (NTSC_CYC < 1 || PAL_CYC < 1) begin : g_bad_period
      $error("line periods must be at least one tick");
   end

   vstd_e             std_w;
   logic              adv_w;
   logic              wrap_w;
   logic [LINE_W-1:0] nxt_line_w;
   logic [CYC_W-1:0]  period_w;
   wire               unused_wdata_bits = ^cmp_wdata_i;

   assign period_w = (std_w == STD_PAL) ? CYC_W'(PAL_CYC) : CYC_W'(NTSC_CYC);

   vline_tick_div #(
      .MAX_CYC (MAX_CYC)
   ) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .period_i (period_w),
      .adv_o    (adv_w)
   );

   vline_counter #(
      .LINE_W     (LINE_W),
      .NTSC_LINES (NTSC_LINES),
      .PAL_LINES  (PAL_LINES)
   ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (adv_w),
      .pal_sel_i  (pal_sel_i),
      .line_o     (line_o),
      .nxt_line_o (nxt_line_w),
      .wrap_o     (wrap_w),
      .std_o      (std_w),
      .retrace_o  (retrace_o)
   );

   vline_present #(
      .LINE_W       (LINE_W),
      .FRAME_CNT_W  (FRAME_CNT_W),
      .PRESENT_LINE (PRESENT_LINE)
   ) u_pres (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .adv_i       (adv_w),
      .nxt_line_i  (nxt_line_w),
      .wrap_i      (wrap_w),
      .base_wr_i   (base_wr_i),
      .present_o   (present_o),
      .frame_cnt_o (frame_cnt_o)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      logic [LINE_W-1:0] cmp_q;
      logic              hit_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cmp_q <= '0;
            hit_q <= 1'b0;
         end else begin
            if (cmp_wr_i)
               cmp_q <= cmp_wdata_i[CMP_LSB[i] +: LINE_W];
            hit_q <= adv_w && (nxt_line_w == cmp_q);
         end
      end

      assign line_hit_o[i] = hit_q;

      // a compare pulse only accompanies a fresh line value
      assert_hit_on_new_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         hit_q |-> (line_o != $past(line_o)));
   end

endmodule

// File: tb/vline_timing_tb.sv
module vline_timing_tb;

   localparam int LW  = 10;
   localparam int FW  = 16;
   localparam int NCY = 2;
   localparam int PCY = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          pal_sel = 1'b0;
   logic          cmp_wr = 1'b0;
   logic [31:0]   cmp_wdata = '0;
   logic          base_wr = 1'b0;
   logic          retrace;
   logic [1:0]    hit;
   logic          present;
   logic [LW-1:0] line;
   logic [FW-1:0] frame;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   vline_timing #(
      .LINE_W      (LW),
      .NTSC_CYC    (NCY),
      .PAL_CYC     (PCY),
      .FRAME_CNT_W (FW)
   ) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .pal_sel_i   (pal_sel),
      .cmp_wr_i    (cmp_wr),
      .cmp_wdata_i (cmp_wdata),
      .base_wr_i   (base_wr),
      .retrace_o   (retrace),
      .line_hit_o  (hit),
      .present_o   (present),
      .line_o      (line),
      .frame_cnt_o (frame)
   );

   // word, inspected line, expected compare A pulse, expected compare B pulse
   localparam int NV = 6;
   localparam logic [31:0] V_WORD [NV] = '{32'h0028_0032, 32'h0028_0032, 32'h0064_0064,
                                           32'hFC14_FC1E, 32'hFC14_FC1E, 32'h0005_0007};
   localparam int          V_LINE [NV] = '{40, 50, 100, 20, 30, 6};
   localparam logic        V_A    [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic        V_B    [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // returns at the first negedge on which line_o shows a new value
   task automatic wait_change(output int n);
      logic [LW-1:0] prev;
      prev = line;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (line == prev && n < 4000);
   endtask

   // returns at the negedge on which line_o has just become the target
   task automatic wait_line(input int target);
      int n = 0;
      while (int'(line) == target && n < 4000) begin
         @(negedge clk);
         n++;
      end
      while (int'(line) != target && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic write_cmp(input logic [31:0] w);
      cmp_wdata = w;
      cmp_wr = 1'b1;
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      int n;
      logic [FW-1:0] f0;
      logic [LW-1:0] held;

      do_reset();
      // R10: reset state
      check(line == 0, "R10 line", int'(line), 0);
      check(frame == 0, "R10 frame", int'(frame), 0);
      check({retrace, hit, present} == 4'b0, "R10 pulses", int'({retrace, hit, present}), 0);
      tick = 1'b1;

      // R1: NTSC line period and tick gating
      wait_change(n);
      wait_change(n);
      check(n == NCY, "R1 ntsc period", n, NCY);
      @(negedge clk);
      tick = 1'b0;
      held = line;
      repeat (10) @(negedge clk);
      check(line == held, "R1 tick low holds", int'(line), int'(held));
      tick = 1'b1;

      // R4 R5: compare vectors
      for (int i = 0; i < NV; i++) begin
         write_cmp(V_WORD[i]);
         wait_line(V_LINE[i]);
         check(hit[0] == V_A[i], "R4 R5 compare A", int'(hit[0]), int'(V_A[i]));
         check(hit[1] == V_B[i], "R4 R5 compare B", int'(hit[1]), int'(V_B[i]));
         @(negedge clk);
         check(hit == 2'b00, "R5 one-cycle pulse", int'(hit), 0);
      end

      // R2 R6 R9: wrap then present at line 65
      wait_line(524);
      wait_change(n);
      check(line == 0, "R2 wrap to zero", int'(line), 0);
      check(retrace == 1'b1, "R2 retrace pulse", int'(retrace), 1);
      @(negedge clk);
      check(retrace == 1'b0, "R2 retrace one cycle", int'(retrace), 0);
      f0 = frame;
      wait_line(64);
      check(present == 1'b0, "R6 no early strobe", int'(present), 0);
      wait_line(65);
      check(present == 1'b1, "R6 strobe at 65", int'(present), 1);
      check(frame == f0 + 1'b1, "R9 frame step", int'(frame), int'(f0 + 1'b1));
      @(negedge clk);
      check(present == 1'b0, "R6 strobe one cycle", int'(present), 0);

      // R7: base write while armed presents early; later triggers do nothing
      wait_line(0);
      wait_line(10);
      f0 = frame;
      base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      check(present == 1'b1, "R7 early strobe", int'(present), 1);
      check(frame == f0 + 1'b1, "R7 R9 frame step", int'(frame), int'(f0 + 1'b1));
      wait_line(65);
      check(present == 1'b0, "R8 no second strobe", int'(present), 0);
      wait_line(70);
      base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      check(present == 1'b0, "R7 unarmed write ignored", int'(present), 0);
      check(frame == f0 + 1'b1, "R7 frame unchanged", int'(frame), int'(f0 + 1'b1));

      // R8: base write on the very edge that reaches line 65
      wait_line(0);
      wait_line(64);
      f0 = frame;
      @(negedge clk);
      base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      check(line == 65, "R8 aligned to line 65", int'(line), 65);
      check(present == 1'b1, "R8 coincident strobe", int'(present), 1);
      @(negedge clk);
      check(present == 1'b0, "R8 single strobe", int'(present), 0);
      check(frame == f0 + 1'b1, "R8 R9 single count", int'(frame), int'(f0 + 1'b1));

      // R3: PAL requested mid-frame takes effect at the next wrap
      wait_line(100);
      pal_sel = 1'b1;
      wait_line(524);
      wait_change(n);
      check(line == 0, "R3 current frame stays 525", int'(line), 0);
      wait_change(n);
      check(n == PCY, "R3 R1 pal period", n, PCY);
      wait_line(624);
      wait_change(n);
      check(line == 0 && retrace == 1'b1, "R3 R2 pal wrap", int'(line), 0);

      // R10: reset selects NTSC even with PAL requested; zero compares
      do_reset();
      check(line == 0 && frame == 0, "R10 reset clears", int'(frame), 0);
      wait_change(n);
      wait_change(n);
      check(n == NCY, "R10 ntsc period after reset", n, NCY);
      wait_line(524);
      wait_change(n);
      check(line == 0, "R10 first frame 525 lines", int'(line), 0);
      check(hit == 2'b11, "R10 R5 zero compares both fire", int'(hit), 3);

      finish_run();
   end

endmodule